// File: doc/BRIEF.md
# Test-Access Instruction and Scan-Path Controller

This block is the test-access logic of a synchronous memory. It runs the standard 16-state test-access state machine from TCK and TMS and holds a 3-bit instruction register. It decodes the current instruction and puts one data register between TDI and TDO: a 1-bit bypass cell, a 32-bit identification register, or a boundary register. The boundary register is made of input-pin cells, output-pin cells and a few cells that have no pin.

The decoded instruction also sets the memory output pads. The pads can follow the functional core, be driven from the boundary update latch, or be forced to high impedance. After any reset the identification instruction is in force. The reserved opcodes act exactly as bypass. The memory array and the pad cells are outside the block: the pads appear as plain input and output vectors. Every pin is a plain level signal, so no stream handshake applies.

Top module: `scan_path_ctrl`

## Requirements
- R1: The active instruction is 3'b001 (identify) after an asynchronous reset, and it is set to 3'b001 again whenever the state machine is in Test-Logic-Reset.
- R2: Under 3'b001, Capture-DR loads the 32-bit ID word, whose bit 0 is always 1. Shift-DR then sends it out of TDO LSB first.
- R3: Capture-IR loads 3'b001 into the instruction shift register, which shifts LSB first. The shifted value becomes the active instruction on the falling TCK edge in Update-IR.
- R4: Opcode 3'b111 and the reserved opcodes 3'b011, 3'b101 and 3'b110 select a 1-bit bypass cell that captures 0, so TDO shows TDI delayed by one cycle.
- R5: Opcode 3'b100 (sample/preload) captures and shifts the boundary register, and Update-DR loads the update latch. The pads keep following core_out and core_oe the whole time.
- R6: Under opcode 3'b000 (external test), from the falling edge of Update-IR onward, pad_out equals the output cells of the update latch and every pad_oe bit is 1.
- R7: Boundary capture layout: bits [5:0] take pin_in, bits [13:6] take the current pad_out, and bits [15:14] take the fixed value 2'b10.
- R8: Under opcode 3'b010 (high-impedance sample), every pad_oe bit is 0 and the boundary register sits between TDI and TDO.
- R9: TDO and tdo_oe change only on falling TCK edges. tdo_oe is 1 only in Shift-IR and Shift-DR.
- R10: trst_n low resets the block asynchronously: the state goes to Test-Logic-Reset and the update latch clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Drive enable for TDO |
| pin_in | input | 6 | Input pin levels as seen by the boundary cells |
| core_out | input | 8 | Functional output data from the memory |
| core_oe | input | 8 | Functional output enables from the memory |
| pad_out | output | 8 | Value sent to the output pads |
| pad_oe | output | 8 | Enables sent to the output pads |

## Verification
The assertions assume that trst_n is released away from TCK edges and that TMS and TDI are stable at every rising TCK edge. They also assume that pin_in, core_out and core_oe do not change while a boundary capture happens. The stimulus changes TMS, TDI and all pad inputs only one time unit after a falling edge. It reads TDO and the pads at that same point, so each rising edge sees settled inputs and each falling-edge update has already taken place.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_st_e;

  typedef enum logic [2:0] {
    OP_EXTEST  = 3'b000, OP_IDCODE = 3'b001, OP_SAMPLEZ = 3'b010, OP_RSV3 = 3'b011,
    OP_SAMPLE  = 3'b100, OP_RSV5   = 3'b101, OP_RSV6    = 3'b110, OP_BYPASS = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {DRS_BYP, DRS_ID, DRS_BSR} dr_sel_e;

  typedef struct packed {
    dr_sel_e sel;
    logic    drive_bsr;
    logic    force_hiz;
  } decode_t;

  function automatic decode_t decode_op(opcode_e op);
    decode_t d;
    d = '{sel: DRS_BYP, drive_bsr: 1'b0, force_hiz: 1'b0};
    case (op)
      OP_EXTEST:  begin d.sel = DRS_BSR; d.drive_bsr = 1'b1; end
      OP_IDCODE:  d.sel = DRS_ID;
      OP_SAMPLEZ: begin d.sel = DRS_BSR; d.force_hiz = 1'b1; end
      OP_SAMPLE:  d.sel = DRS_BSR;
      default:    d.sel = DRS_BYP;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_e st
);
  tap_st_e nxt;

  always_comb begin
    case (st)
      TLR:    nxt = tms ? TLR    : RTI;
      RTI:    nxt = tms ? SEL_DR : RTI;
      SEL_DR: nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR: nxt = tms ? EX1_DR : SH_DR;
      SH_DR:  nxt = tms ? EX1_DR : SH_DR;
      EX1_DR: nxt = tms ? UPD_DR : PA_DR;
      PA_DR:  nxt = tms ? EX2_DR : PA_DR;
      EX2_DR: nxt = tms ? UPD_DR : SH_DR;
      UPD_DR: nxt = tms ? SEL_DR : RTI;
      SEL_IR: nxt = tms ? TLR    : CAP_IR;
      CAP_IR: nxt = tms ? EX1_IR : SH_IR;
      SH_IR:  nxt = tms ? EX1_IR : SH_IR;
      EX1_IR: nxt = tms ? UPD_IR : PA_IR;
      PA_IR:  nxt = tms ? EX2_IR : PA_IR;
      EX2_IR: nxt = tms ? UPD_IR : SH_IR;
      UPD_IR: nxt = tms ? SEL_DR : RTI;
      default: nxt = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st <= TLR;
    else         st <= nxt;
endmodule

// File: rtl/scan_instr_reg.sv
module scan_instr_reg
  import scan_pkg::*;
#(
  parameter int IR_W = 3
) (
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tdi,
  input  tap_st_e st,
  output opcode_e ir,
  output logic    ir_so
);
  localparam logic [IR_W-1:0] CAP_PAT = IR_W'(2'b01);

  logic [IR_W-1:0] sr;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)          sr <= CAP_PAT;
    else if (st == CAP_IR) sr <= CAP_PAT;
    else if (st == SH_IR)  sr <= {tdi, sr[IR_W-1:1]};

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)           ir <= OP_IDCODE;
    else if (st == TLR)    ir <= OP_IDCODE;
    else if (st == UPD_IR) ir <= opcode_e'(sr);

  assign ir_so = sr[0];

  // R1
  ir_default_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == TLR) |-> (ir == OP_IDCODE));
  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == CAP_IR) |=> (sr[1:0] == 2'b01));
endmodule

// File: rtl/scan_data_regs.sv
module scan_data_regs
  import scan_pkg::*;
#(
  parameter int          BSR_LEN = 16,
  parameter logic [31:0] ID_CODE = 32'h2B3C_4D5E
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tdi,
  input  tap_st_e            st,
  input  dr_sel_e            sel,
  input  logic [BSR_LEN-1:0] bsr_cap,
  output logic               dr_so,
  output logic [BSR_LEN-1:0] bsr_upd
);
  localparam logic [31:0] ID_WORD = {ID_CODE[31:1], 1'b1};

  logic               byp;
  logic [31:0]        id_sr;
  logic [BSR_LEN-1:0] bsr;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      byp   <= 1'b0;
      id_sr <= ID_WORD;
      bsr   <= '0;
    end else if (st == CAP_DR) begin
      case (sel)
        DRS_ID:  id_sr <= ID_WORD;
        DRS_BSR: bsr   <= bsr_cap;
        default: byp   <= 1'b0;
      endcase
    end else if (st == SH_DR) begin
      case (sel)
        DRS_ID:  id_sr <= {tdi, id_sr[31:1]};
        DRS_BSR: bsr   <= {tdi, bsr[BSR_LEN-1:1]};
        default: byp   <= tdi;
      endcase
    end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)                              bsr_upd <= '0;
    else if (st == UPD_DR && sel == DRS_BSR)  bsr_upd <= bsr;

  always_comb
    case (sel)
      DRS_ID:  dr_so = id_sr[0];
      DRS_BSR: dr_so = bsr[0];
      default: dr_so = byp;
    endcase

  // R4
  byp_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == CAP_DR && sel == DRS_BYP) |=> (byp == 1'b0));
  // R2
  id_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == CAP_DR && sel == DRS_ID) |=> (id_sr[0] == 1'b1));
endmodule

// File: rtl/scan_path_ctrl.sv
module scan_path_ctrl
  import scan_pkg::*;
#(
  parameter int                N_IN    = 6,
  parameter int                N_OUT   = 8,
  parameter int                N_FIX   = 2,
  parameter logic [N_FIX-1:0]  FIX_VAL = 2'b10,
  parameter logic [31:0]       ID_CODE = 32'h2B3C_4D5E
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe
);
  localparam int BSR_LEN = N_IN + N_OUT + N_FIX;
  localparam int OUT_LO  = N_IN;

  tap_st_e            st;
  opcode_e            ir;
  logic               ir_so, dr_so;
  decode_t            dec;
  logic [BSR_LEN-1:0] bsr_cap, bsr_upd;
  logic [N_OUT-1:0]   upd_out;

  scan_tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .st(st));

  scan_instr_reg #(.IR_W(3)) u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .ir(ir), .ir_so(ir_so));

  assign dec     = decode_op(ir);
  assign bsr_cap = {FIX_VAL, pad_out, pin_in};

  scan_data_regs #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_CODE)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .sel(dec.sel),
    .bsr_cap(bsr_cap), .dr_so(dr_so), .bsr_upd(bsr_upd));

  assign upd_out = bsr_upd[OUT_LO +: N_OUT];

  always_comb begin
    if (dec.drive_bsr) begin
      pad_out = upd_out;
      pad_oe  = '1;
    end else begin
      pad_out = core_out;
      pad_oe  = dec.force_hiz ? '0 : core_oe;
    end
  end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      case (st)
        SH_IR:   begin tdo <= ir_so; tdo_oe <= 1'b1; end
        SH_DR:   begin tdo <= dr_so; tdo_oe <= 1'b1; end
        default: tdo_oe <= 1'b0;
      endcase
    end

  // R9
  tdo_window_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (st == SH_IR || st == SH_DR));
  // R8
  hiz_pads_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir == OP_SAMPLEZ) |-> (pad_oe == '0));
  // R6
  extest_drive_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir == OP_EXTEST) |-> (pad_oe == '1));
endmodule

// File: tb/test_scan_path_ctrl.sv
module test_scan_path_ctrl;
  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe;
  logic [5:0] pin_in = '0;
  logic [7:0] core_out = '0, core_oe = '0, pad_out, pad_oe;
  int vecs = 0, errs = 0;

  localparam logic [31:0] EXP_ID  = 32'h2B3C_4D5F;
  localparam logic [1:0]  EXP_FIX = 2'b10;

  always #4 tck = ~tck;

  scan_path_ctrl i_scan_path_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o, output logic oe);
    tms = m; tdi = d; o = tdo; oe = tdo_oe;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic idle(input logic m);
    logic o, oe;
    step(m, 1'b0, o, oe);
  endtask

  task automatic scan_ir(input logic [2:0] code);
    logic o, oe; logic [2:0] got; int oe_bad = 0;
    idle(1); idle(1); idle(0); idle(0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], o, oe);
      got[i] = o;
      if (!oe) oe_bad++;
    end
    idle(1); idle(0);
    chk("R3 ir capture", {29'd0, got}, 32'd1);
    chk("R9 tdo_oe in Shift-IR", oe_bad, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic o, oe; int oe_bad = 0;
    dout = '0;
    idle(1); idle(0); idle(0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o, oe);
      dout[i] = o;
      if (!oe) oe_bad++;
    end
    idle(1); idle(0);
    chk("R9 tdo_oe in Shift-DR", oe_bad, 0);
  endtask

  task automatic t_reset;
    logic [31:0] q;
    trst_n = 1'b0; #13; trst_n = 1'b1;
    @(negedge tck); #1;
    core_out = 8'h3C; core_oe = 8'hF0;
    idle(0); #1;
    chk("R9 tdo_oe idle", {31'd0, tdo_oe}, 0);
    chk("R1 pads follow core", {16'd0, pad_oe, pad_out}, {16'd0, 8'hF0, 8'h3C});
    scan_dr(32, 32'h0, q);
    chk("R1 R2 id word", q, EXP_ID);
  endtask

  task automatic t_bypass;
    logic [31:0] q;
    logic [2:0] ops [4] = '{3'b111, 3'b011, 3'b101, 3'b110};
    foreach (ops[k]) begin
      scan_ir(ops[k]);
      scan_dr(8, 32'hA5, q);
      chk("R4 bypass delay", q, {24'd0, 8'h4A});
    end
  endtask

  task automatic t_sample_extest;
    logic [31:0] q;
    logic [15:0] p = 16'h5A96, r = 16'hC3E1;
    pin_in = 6'h2B;
    scan_ir(3'b100);
    scan_dr(16, {16'd0, p}, q);
    chk("R5 R7 sample capture", q, {16'd0, EXP_FIX, 8'h3C, 6'h2B});
    chk("R5 pads undisturbed", {16'd0, pad_oe, pad_out}, {16'd0, 8'hF0, 8'h3C});
    scan_ir(3'b000);
    chk("R6 extest drive", {16'd0, pad_oe, pad_out}, {16'd0, 8'hFF, p[13:6]});
    pin_in = 6'h15;
    scan_dr(16, {16'd0, r}, q);
    chk("R7 extest capture", q, {16'd0, EXP_FIX, p[13:6], 6'h15});
    chk("R6 extest update", {24'd0, pad_out}, {24'd0, r[13:6]});
  endtask

  task automatic t_samplez;
    logic [31:0] q;
    int hiz_bad = 0;
    core_out = 8'h81; pin_in = 6'h3F;
    scan_ir(3'b010);
    chk("R8 hiz pads", {24'd0, pad_oe}, 0);
    fork
      scan_dr(16, 32'h0, q);
      repeat (20) begin @(negedge tck); #2; if (pad_oe !== 8'h00) hiz_bad++; end
    join
    chk("R8 hiz during scan", hiz_bad, 0);
    chk("R8 R7 bsr in path", q, {16'd0, EXP_FIX, 8'h81, 6'h3F});
  endtask

  task automatic t_tlr_trst;
    logic [31:0] q;
    scan_ir(3'b111);
    repeat (5) idle(1);
    idle(0);
    scan_dr(32, 32'h0, q);
    chk("R1 tlr restores id", q, EXP_ID);
    scan_ir(3'b000);
    chk("R6 extest before trst", {24'd0, pad_oe}, 32'hFF);
    #1; trst_n = 1'b0; #2;
    chk("R10 async reset pads", {16'd0, pad_oe, pad_out}, {16'd0, 8'hF0, 8'h81});
    trst_n = 1'b1;
    @(negedge tck); #1;
    idle(0);
    scan_dr(32, 32'h0, q);
    chk("R10 id after trst", q, EXP_ID);
  endtask

  initial begin
    #1600000;
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_sample_extest();
    t_samplez();
    t_tlr_trst();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule